// File: doc/BRIEF.md
# Sixteen-bit Execution Unit with Overflow Register

This block executes the fifteen two-operand opcodes of a small 16-bit processor. Each operation takes two operand words and the current value of a dedicated overflow register. It returns the word to write back to the first operand, a new overflow value with its own write strobe, and a request to skip the following instruction. The instruction fetch, the operand fetch and the writeback routing sit outside this block.

The surrounding core pulses `start_i` with the opcode and operands. It then waits for the one-cycle `done_o` pulse and uses the result fields in that cycle. Most opcodes finish one cycle after the start. Division and remainder with a non-zero divisor run on an iterative bit-serial divider and hold `busy_o` high while it works. A start is accepted only while `busy_o` is low. The overflow output always shows the value the register should hold after the operation: either the new value, or the incoming `ovf_i` passed through when the operation leaves the register alone.

Top module: `ovf_alu`

## Requirements
- R1: Opcode 0x1 writes b. Opcodes 0x9, 0xA and 0xB write a AND b, a OR b and a XOR b. All four leave the overflow register alone: `ovf_we_o` stays 0 and `ovf_o` equals `ovf_i`.
- R2: Opcode 0x2 writes (a+b) mod 65536 and writes the overflow register with 0x0001 when a carry leaves bit 15, otherwise with 0x0000.
- R3: Opcode 0x3 writes (a-b) mod 65536 and writes the overflow register with 0xFFFF when b > a, otherwise with 0x0000.
- R4: Opcode 0x4 writes bits 15:0 of the unsigned 32-bit product and writes bits 31:16 of that product to the overflow register.
- R5: Opcode 0x5 with b != 0 writes floor(a/b) and writes the overflow register with bits 15:0 of floor((a*65536)/b).
- R6: Opcode 0x6 with b != 0 writes a mod b and leaves the overflow register alone.
- R7: With b == 0, opcode 0x5 writes 0 to both the result and the overflow register. Opcode 0x6 writes result 0 and leaves the overflow register alone. Both finish one cycle after the start.
- R8: Opcode 0x7 forms the 32-bit value a shifted left by b. Bits 15:0 go to the result and bits 31:16 go to the overflow register. When b >= 32, both are 0.
- R9: Opcode 0x8 forms the 32-bit value (a*65536) shifted right by b. Bits 31:16 go to the result and bits 15:0 go to the overflow register. When b >= 32, both are 0.
- R10: Opcodes 0xC, 0xD, 0xE and 0xF test a==b, a!=b, a>b (unsigned) and (a AND b)!=0. `skip_o` is 1 exactly when the test is false. These opcodes write neither the result nor the overflow register.
- R11: Every accepted start produces exactly one `done_o` pulse. Every operation other than 0x5 or 0x6 with a non-zero b gives `done_o` one cycle after the start. A divide with a non-zero b holds `busy_o` high until its `done_o`.
- R12: During reset and outside `done_o`, the signals `done_o`, `busy_o`, `result_we_o`, `ovf_we_o` and `skip_o` are 0.
- R13: Opcode 0x0 completes in one cycle with no write and no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted when busy_o is 0) |
| op_i | input | 4 | Opcode |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| ovf_i | input | 16 | Current overflow register value |
| busy_o | output | 1 | Divider in use, start ignored |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Value for operand a |
| result_we_o | output | 1 | Result write strobe |
| ovf_o | output | 16 | Overflow register value after the operation |
| ovf_we_o | output | 1 | Overflow write strobe |
| skip_o | output | 1 | Skip the next instruction |

## Verification
The bench goes after the overflow edges first:
- An add of 0xFFFF+1: a design with a carry that went astray would write 0xFFFF or drop the 0x0001.
- A subtract of 0-1: a design that flagged borrow as 1 instead of all ones would show up here.
- Shifts by 0, 15, 16, 31, 32 and 40: a design that masked the count to five bits would wrap instead of giving zero.

It then checks divide and remainder in these cases:
- A zero divisor: a design that forgot this case would hang in the divider or return all ones.
- Fractional-quotient cases such as 1/3: a divider that lost its low quotient bits would return 0 instead of 0x5555.
- Remainder: a design that captured the remainder at the wrong step would return the 32-bit remainder.

Compare and logical opcodes are run with a distinctive incoming overflow value. An unwanted overflow write, or a flipped skip polarity, therefore shows at the ports.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'h0, OP_SET = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
    OP_MUL  = 4'h4, OP_DIV = 4'h5, OP_MOD = 4'h6, OP_SHL = 4'h7,
    OP_SHR  = 4'h8, OP_AND = 4'h9, OP_BOR = 4'hA, OP_XOR = 4'hB,
    OP_IFE  = 4'hC, OP_IFN = 4'hD, OP_IFG = 4'hE, OP_IFB = 4'hF
  } alu_op_e;
endpackage

// File: rtl/ovf_alu_ops.sv
module ovf_alu_ops
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   ovf_i,
  output logic [W-1:0]   res_o,
  output logic           res_we_o,
  output logic [W-1:0]   ovf_o,
  output logic           ovf_we_o,
  output logic           skip_o,
  output logic           long_o
);
  localparam int DW = 2 * W;
  localparam int SW = $clog2(DW);

  logic [W:0]    sum_w;
  logic [W:0]    dif_w;
  logic [DW-1:0] prod_w;
  logic [DW-1:0] shl_w;
  logic [DW-1:0] shr_w;
  logic          big_shift;
  logic [SW-1:0] sh_amt;
  logic          b_zero;

  assign sum_w     = {1'b0, a_i} + {1'b0, b_i};
  assign dif_w     = {1'b0, a_i} - {1'b0, b_i};
  assign prod_w    = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
  assign big_shift = ({1'b0, b_i} >= (W+1)'(DW));
  assign sh_amt    = b_i[SW-1:0];
  assign shl_w     = big_shift ? '0 : ({{W{1'b0}}, a_i} << sh_amt);
  assign shr_w     = big_shift ? '0 : ({a_i, {W{1'b0}}} >> sh_amt);
  assign b_zero    = (b_i == '0);

  always_comb begin
    res_o    = '0;
    res_we_o = 1'b0;
    ovf_o    = ovf_i;
    ovf_we_o = 1'b0;
    skip_o   = 1'b0;
    long_o   = 1'b0;
    unique case (op_i)
      OP_NONE: ;
      OP_SET: begin res_o = b_i;        res_we_o = 1'b1; end
      OP_AND: begin res_o = a_i & b_i;  res_we_o = 1'b1; end
      OP_BOR: begin res_o = a_i | b_i;  res_we_o = 1'b1; end
      OP_XOR: begin res_o = a_i ^ b_i;  res_we_o = 1'b1; end
      OP_ADD: begin
        res_o = sum_w[W-1:0]; res_we_o = 1'b1;
        ovf_o = {{(W-1){1'b0}}, sum_w[W]}; ovf_we_o = 1'b1;
      end
      OP_SUB: begin
        res_o = dif_w[W-1:0]; res_we_o = 1'b1;
        ovf_o = {W{dif_w[W]}}; ovf_we_o = 1'b1;
      end
      OP_MUL: begin
        res_o = prod_w[W-1:0]; res_we_o = 1'b1;
        ovf_o = prod_w[DW-1:W]; ovf_we_o = 1'b1;
      end
      OP_DIV: begin
        if (b_zero) begin
          res_we_o = 1'b1; ovf_o = '0; ovf_we_o = 1'b1;
        end else begin
          long_o = 1'b1;
        end
      end
      OP_MOD: begin
        if (b_zero) res_we_o = 1'b1;
        else        long_o   = 1'b1;
      end
      OP_SHL: begin
        res_o = shl_w[W-1:0]; res_we_o = 1'b1;
        ovf_o = shl_w[DW-1:W]; ovf_we_o = 1'b1;
      end
      OP_SHR: begin
        res_o = shr_w[DW-1:W]; res_we_o = 1'b1;
        ovf_o = shr_w[W-1:0]; ovf_we_o = 1'b1;
      end
      OP_IFE: skip_o = (a_i != b_i);
      OP_IFN: skip_o = (a_i == b_i);
      OP_IFG: skip_o = (a_i <= b_i);
      OP_IFB: skip_o = ((a_i & b_i) == '0);
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == OP_ADD) begin
      AST_ADD_CARRY_RANGE: assert (ovf_o <= W'(1)); // R2
    end
    if (op_i == OP_SUB) begin
      AST_SUB_BORROW_FORM: assert (ovf_o == '0 || ovf_o == '1); // R3
    end
    if (op_i inside {OP_IFE, OP_IFN, OP_IFG, OP_IFB}) begin
      AST_CMP_NO_WRITE: assert (!res_we_o && !ovf_we_o); // R10
    end
  end
endmodule

// File: rtl/ovf_alu_div.sv
module ovf_alu_div #(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic            run_o,
  output logic            done_o,
  output logic [2*W-1:0]  quot_o,
  output logic [W-1:0]    rem_o
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW);

  logic [DW-1:0] dvd_q, dvd_nx;
  logic [W-1:0]  dvs_q, dvs_nx;
  logic [W-1:0]  rem_q, rem_nx;
  logic [W-1:0]  mod_q, mod_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          run_q, run_nx;
  logic          done_q, done_nx;

  logic [W:0]    rem_sh;
  logic [W:0]    rem_sub;
  logic          ge;

  assign rem_sh  = {rem_q, dvd_q[DW-1]};
  assign ge      = (rem_sh >= {1'b0, dvs_q});
  assign rem_sub = ge ? (rem_sh - {1'b0, dvs_q}) : rem_sh;

  always_comb begin
    dvd_nx  = dvd_q;
    dvs_nx  = dvs_q;
    rem_nx  = rem_q;
    mod_nx  = mod_q;
    cnt_nx  = cnt_q;
    run_nx  = run_q;
    done_nx = 1'b0;
    if (start_i) begin
      dvd_nx = {a_i, {W{1'b0}}};
      dvs_nx = b_i;
      rem_nx = '0;
      cnt_nx = '0;
      run_nx = 1'b1;
    end else if (run_q) begin
      dvd_nx = {dvd_q[DW-2:0], ge};
      rem_nx = rem_sub[W-1:0];
      cnt_nx = cnt_q + CW'(1);
      if (cnt_q == CW'(W-1)) mod_nx = rem_sub[W-1:0];
      if (cnt_q == CW'(DW-1)) begin
        run_nx  = 1'b0;
        done_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      mod_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      dvd_q  <= dvd_nx;
      dvs_q  <= dvs_nx;
      rem_q  <= rem_nx;
      mod_q  <= mod_nx;
      cnt_q  <= cnt_nx;
      run_q  <= run_nx;
      done_q <= done_nx;
    end
  end

  assign run_o  = run_q;
  assign done_o = done_q;
  assign quot_o = dvd_q;
  assign rem_o  = mod_q;

  AST_DIV_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run_q); // R11
  AST_DIV_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start_i && cnt_q != CW'(DW-1)) |=> (run_q && cnt_q == $past(cnt_q) + CW'(1))); // R5
endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] ovf_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o,
  output logic         result_we_o,
  output logic [W-1:0] ovf_o,
  output logic         ovf_we_o,
  output logic         skip_o
);
  localparam int DW = 2 * W;

  alu_op_e       op_e;
  logic [W-1:0]  u_res, u_ovf;
  logic          u_res_we, u_ovf_we, u_skip, u_long;
  logic          accept, launch;
  logic          div_run, div_done;
  logic [DW-1:0] div_quot;
  logic [W-1:0]  div_rem;

  logic          pend_q, pend_nx;
  alu_op_e       pop_q, pop_nx;
  logic [W-1:0]  povf_q, povf_nx;
  logic          done_q, done_nx;
  logic [W-1:0]  res_q, res_nx;
  logic          rwe_q, rwe_nx;
  logic [W-1:0]  ovf_q, ovf_nx;
  logic          owe_q, owe_nx;
  logic          skip_q, skip_nx;

  assign op_e   = alu_op_e'(op_i);
  assign accept = start_i && !pend_q;
  assign launch = accept && u_long;

  ovf_alu_ops #(.W(W)) u_ops (
    .op_i     (op_e),
    .a_i      (a_i),
    .b_i      (b_i),
    .ovf_i    (ovf_i),
    .res_o    (u_res),
    .res_we_o (u_res_we),
    .ovf_o    (u_ovf),
    .ovf_we_o (u_ovf_we),
    .skip_o   (u_skip),
    .long_o   (u_long)
  );

  ovf_alu_div #(.W(W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (launch),
    .a_i     (a_i),
    .b_i     (b_i),
    .run_o   (div_run),
    .done_o  (div_done),
    .quot_o  (div_quot),
    .rem_o   (div_rem)
  );

  always_comb begin
    pend_nx = pend_q;
    pop_nx  = pop_q;
    povf_nx = povf_q;
    done_nx = 1'b0;
    res_nx  = res_q;
    rwe_nx  = 1'b0;
    ovf_nx  = ovf_q;
    owe_nx  = 1'b0;
    skip_nx = 1'b0;
    if (launch) begin
      pend_nx = 1'b1;
      pop_nx  = op_e;
      povf_nx = ovf_i;
    end else if (accept) begin
      done_nx = 1'b1;
      res_nx  = u_res;
      rwe_nx  = u_res_we;
      ovf_nx  = u_ovf;
      owe_nx  = u_ovf_we;
      skip_nx = u_skip;
    end
    if (div_done) begin
      pend_nx = 1'b0;
      done_nx = 1'b1;
      rwe_nx  = 1'b1;
      if (pop_q == OP_DIV) begin
        res_nx = div_quot[DW-1:W];
        ovf_nx = div_quot[W-1:0];
        owe_nx = 1'b1;
      end else begin
        res_nx = div_rem;
        ovf_nx = povf_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pop_q  <= OP_NONE;
      povf_q <= '0;
      done_q <= 1'b0;
      res_q  <= '0;
      rwe_q  <= 1'b0;
      ovf_q  <= '0;
      owe_q  <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      pend_q <= pend_nx;
      pop_q  <= pop_nx;
      povf_q <= povf_nx;
      done_q <= done_nx;
      res_q  <= res_nx;
      rwe_q  <= rwe_nx;
      ovf_q  <= ovf_nx;
      owe_q  <= owe_nx;
      skip_q <= skip_nx;
    end
  end

  assign busy_o      = pend_q;
  assign done_o      = done_q;
  assign result_o    = res_q;
  assign result_we_o = rwe_q;
  assign ovf_o       = ovf_q;
  assign ovf_we_o    = owe_q;
  assign skip_o      = skip_q;

  AST_SHORT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !(op_e inside {OP_DIV, OP_MOD} && b_i != '0)) |=> done_o); // R11
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !div_done) |=> busy_o); // R11
  AST_DIV_HAS_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (div_run || div_done)); // R5
  AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && skip_o) |-> (!result_we_o && !ovf_we_o)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (!result_we_o && !ovf_we_o && !skip_o)); // R12
endmodule

// File: tb/ovf_alu_tb.sv
module ovf_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [15:0] a_i = '0, b_i = '0, ovf_i = '0;
  logic        busy_o, done_o, result_we_o, ovf_we_o, skip_o;
  logic [15:0] result_o, ovf_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [3:0]  op;
    logic [15:0] res;
    logic        rwe;
    logic [15:0] ovf;
    logic        owe;
    logic        skip;
    logic        single;
    int          t0;
    string       tag;
  } exp_t;

  exp_t sb[$];

  ovf_alu u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .ovf_i(ovf_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .result_we_o(result_we_o), .ovf_o(ovf_o),
    .ovf_we_o(ovf_we_o), .skip_o(skip_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t model(input logic [3:0] op, input logic [15:0] a,
                                 input logic [15:0] b, input logic [15:0] o);
    exp_t e;
    logic [31:0] w;
    e.op = op; e.res = '0; e.rwe = 1'b0; e.ovf = o; e.owe = 1'b0;
    e.skip = 1'b0; e.single = 1'b1; e.t0 = 0; e.tag = "R13";
    case (op)
      4'h1: begin e.res = b;     e.rwe = 1; e.tag = "R1"; end
      4'h9: begin e.res = a & b; e.rwe = 1; e.tag = "R1"; end
      4'hA: begin e.res = a | b; e.rwe = 1; e.tag = "R1"; end
      4'hB: begin e.res = a ^ b; e.rwe = 1; e.tag = "R1"; end
      4'h2: begin
        w = 32'(a) + 32'(b);
        e.res = w[15:0]; e.rwe = 1; e.ovf = (w > 32'hFFFF) ? 16'h1 : 16'h0; e.owe = 1; e.tag = "R2";
      end
      4'h3: begin
        e.res = a - b; e.rwe = 1; e.ovf = (b > a) ? 16'hFFFF : 16'h0; e.owe = 1; e.tag = "R3";
      end
      4'h4: begin
        w = 32'(a) * 32'(b);
        e.res = w[15:0]; e.rwe = 1; e.ovf = w[31:16]; e.owe = 1; e.tag = "R4";
      end
      4'h5: begin
        e.rwe = 1; e.owe = 1;
        if (b == 0) begin e.res = 0; e.ovf = 0; e.tag = "R7"; end
        else begin
          w = {a, 16'h0} / 32'(b);
          e.res = a / b; e.ovf = w[15:0]; e.single = 0; e.tag = "R5";
        end
      end
      4'h6: begin
        e.rwe = 1;
        if (b == 0) begin e.res = 0; e.tag = "R7"; end
        else begin e.res = a % b; e.single = 0; e.tag = "R6"; end
      end
      4'h7: begin
        w = (b >= 32) ? 32'h0 : (32'(a) << b);
        e.res = w[15:0]; e.ovf = w[31:16]; e.rwe = 1; e.owe = 1; e.tag = "R8";
      end
      4'h8: begin
        w = (b >= 32) ? 32'h0 : ({a, 16'h0} >> b);
        e.res = w[31:16]; e.ovf = w[15:0]; e.rwe = 1; e.owe = 1; e.tag = "R9";
      end
      4'hC: begin e.skip = !(a == b);         e.tag = "R10"; end
      4'hD: begin e.skip = !(a != b);         e.tag = "R10"; end
      4'hE: begin e.skip = !(a > b);          e.tag = "R10"; end
      4'hF: begin e.skip = !((a & b) != 0);   e.tag = "R10"; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic issue(input logic [3:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] o);
    exp_t e;
    while (busy_o) @(negedge clk);
    e = model(op, a, b, o);
    e.t0 = cyc;
    sb.push_back(e);
    op_i = op; a_i = a; b_i = b; ovf_i = o; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Monitor: scoreboard compare at each done pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected done: actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (result_we_o !== e.rwe || (e.rwe && result_o !== e.res) ||
            ovf_o !== e.ovf || ovf_we_o !== e.owe || skip_o !== e.skip) begin
          errors++;
          $display("FAIL %s op=%h: actual res=%h rwe=%b ovf=%h owe=%b skip=%b expected res=%h rwe=%b ovf=%h owe=%b skip=%b",
                   e.tag, e.op, result_o, result_we_o, ovf_o, ovf_we_o, skip_o,
                   e.res, e.rwe, e.ovf, e.owe, e.skip);
        end
        if (e.single) begin
          checks++;
          if (cyc - e.t0 != 1) begin
            errors++;
            $display("FAIL R11 latency op=%h: actual=%0d expected=1", e.op, cyc - e.t0);
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (done_o !== 0 || busy_o !== 0 || result_we_o !== 0 || ovf_we_o !== 0 || skip_o !== 0) begin
      errors++;
      $display("FAIL R12 reset outputs: actual=%b%b%b%b%b expected=00000",
               done_o, busy_o, result_we_o, ovf_we_o, skip_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1 set and logic keep overflow
    issue(4'h1, 16'h1111, 16'hBEEF, 16'h1234);
    issue(4'h9, 16'hF0F0, 16'h3C3C, 16'hA5A5);
    issue(4'hA, 16'hF0F0, 16'h0F01, 16'hA5A5);
    issue(4'hB, 16'hFFFF, 16'h1234, 16'h5A5A);
    // R2 carry edge
    issue(4'h2, 16'hFFFF, 16'h0001, 16'h7777);
    issue(4'h2, 16'h7FFF, 16'h0001, 16'h7777);
    // R3 borrow edge
    issue(4'h3, 16'h0000, 16'h0001, 16'h0000);
    issue(4'h3, 16'h0005, 16'h0005, 16'hFFFF);
    // R4 product high half
    issue(4'h4, 16'hFFFF, 16'hFFFF, 16'h0);
    // R5 fractional quotient
    issue(4'h5, 16'h0001, 16'h0003, 16'h0);
    issue(4'h5, 16'hFFFF, 16'h0001, 16'h0);
    issue(4'h5, 16'h1234, 16'hFFFF, 16'h0);
    // R6 remainder keeps overflow
    issue(4'h6, 16'hFFFF, 16'h0007, 16'h4321);
    issue(4'h6, 16'h0003, 16'h0009, 16'h4321);
    // R7 divide by zero
    issue(4'h5, 16'h1234, 16'h0000, 16'h9999);
    issue(4'h6, 16'h1234, 16'h0000, 16'h9999);
    // R8 and R9 shift counts
    issue(4'h7, 16'h8001, 16'd0, 16'h1);
    issue(4'h7, 16'h8001, 16'd15, 16'h1);
    issue(4'h7, 16'hABCD, 16'd16, 16'h1);
    issue(4'h7, 16'hABCD, 16'd31, 16'h1);
    issue(4'h7, 16'hABCD, 16'd32, 16'h1);
    issue(4'h7, 16'hABCD, 16'd40, 16'h1);
    issue(4'h8, 16'h8001, 16'd1, 16'h1);
    issue(4'h8, 16'hABCD, 16'd16, 16'h1);
    issue(4'h8, 16'hABCD, 16'd31, 16'h1);
    issue(4'h8, 16'hABCD, 16'd32, 16'h1);
    // R10 compares
    issue(4'hC, 16'h5, 16'h5, 16'hCAFE);
    issue(4'hC, 16'h5, 16'h6, 16'hCAFE);
    issue(4'hD, 16'h5, 16'h5, 16'hCAFE);
    issue(4'hE, 16'h8000, 16'h7FFF, 16'hCAFE);
    issue(4'hE, 16'h7FFF, 16'h7FFF, 16'hCAFE);
    issue(4'hF, 16'h00F0, 16'h0F00, 16'hCAFE);
    issue(4'hF, 16'h00F0, 16'h0010, 16'hCAFE);
    // R13 opcode zero
    issue(4'h0, 16'h1, 16'h2, 16'h3333);
    // mixed patterns, R11 one done per start
    for (int i = 0; i < 300; i++) begin
      logic [3:0]  op;
      logic [15:0] a, b;
      op = 4'($urandom_range(0, 15));
      a  = 16'($urandom);
      b  = 16'($urandom);
      if (op == 4'h7 || op == 4'h8) b = 16'($urandom_range(0, 40));
      if ((op == 4'h5 || op == 4'h6) && ($urandom_range(0, 5) == 0)) b = 16'h0;
      if (op >= 4'hC && ($urandom_range(0, 3) == 0)) b = a;
      issue(op, a, b, 16'($urandom));
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    checks++;
    if (busy_o !== 0) begin
      errors++;
      $display("FAIL R11 busy at end: actual=%b expected=0", busy_o);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog: actual=hung expected=complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule